// File: doc/BRIEF.md
# Timer Input Capture Channel

This block timestamps events on an external signal against a free-running 16-bit counter. A control bit chooses which edge of the capture pin counts as an event. On that edge the channel copies the counter value into a 16-bit capture register, which software can only read, and raises a capture flag. The flag stays raised until software writes a one to it.

Software reads the capture register one byte at a time over an 8-bit port. To keep the two bytes consistent, it reads the low byte first. That read also copies the upper byte into a holding byte. A later read of the upper byte returns the holding byte, so a capture that lands between the two reads cannot produce a torn value. The pin is asynchronous, so it passes through a two-flop synchroniser before edge detection.

Top module: `capt_unit`

## Requirements
- R1: After reset the capture register holds zero and the flag is low. Reads of the low byte (`rdAddr`=0) and the high byte (`rdAddr`=1) both return 0.
- R2: With `edgeRise`=1, a 0-to-1 change on `capPin` captures a value. The pin must be stable before clock edge k. The value captured is `cntVal` as sampled at edge k+2, and it is visible after that edge. The flag is still low after edge k+1.
- R3: With `edgeRise`=0, a 1-to-0 change on `capPin` captures `cntVal` with the same latency as R2.
- R4: A pin change of the polarity not selected by `edgeRise` is ignored. The flag stays low and both bytes read back the previous capture.
- R5: A capture sets `capFlag`. The flag stays set until a cycle with `flagWrEn`=1 and `flagWrBit`=1 clears it. A write with `flagWrBit`=0 has no effect.
- R6: If a capture and a clearing write fall in the same cycle, the flag ends that cycle set.
- R7: A read with `rdAddr`=0 returns bits 7:0 of the capture register and copies bits 15:8 into the holding byte. A read with `rdAddr`=1 returns the holding byte.
- R8: A capture that happens after a low-byte read does not alter the holding byte. A following high-byte read still returns the upper byte from before that capture.
- R9: If a low-byte read and a capture fall in the same cycle, the read returns the old low byte. The holding byte receives the old upper byte.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| capPin | input | 1 | Asynchronous capture event input |
| edgeRise | input | 1 | 1 selects the rising edge, 0 selects the falling edge |
| cntVal | input | 16 | Current counter value |
| rdEn | input | 1 | Read strobe for the byte port |
| rdAddr | input | 1 | 0 selects the low byte, 1 selects the holding byte |
| rdData | output | 8 | Read data (combinational from `rdAddr`) |
| flagWrEn | input | 1 | Write strobe for the flag |
| flagWrBit | input | 1 | Write data; a one clears the flag |
| capFlag | output | 1 | Capture flag |

## Verification
Two pairs of functions can share a clock edge: a capture and a clearing write of the flag, and a capture and a low-byte read. The bench knows the latency is three edges from the pin change to the capture. It changes the pin, waits two edges, and then asserts the clear or the low read so that it lands on the capturing edge. It then checks three things: the flag survives the clear, the low read returns the previous low byte, and the later high read returns the previous upper byte rather than the new one.

// File: rtl/capt_pkg.sv
package capt_pkg;
  // Strobes passed from control to datapath, one cycle each
  typedef struct packed {
    logic capture;  // selected edge seen on the synchronised pin
    logic loRead;   // low-byte read accepted this cycle
    logic flagClr;  // write-one-to-clear on the flag
  } captStb_t;
endpackage

// File: rtl/capt_ctrl.sv
module capt_ctrl
  import capt_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic     clk,
  input  logic     rstN,
  input  logic     capPin,
  input  logic     edgeRise,
  input  logic     rdEn,
  input  logic     rdAddr,
  input  logic     flagWrEn,
  input  logic     flagWrBit,
  output captStb_t stb
);
  localparam int LAST = SYNC_STAGES - 1;

  logic [SYNC_STAGES-1:0] syncQ;
  logic                   prevQ;
  logic                   seenRise;
  logic                   seenFall;

  // Synchroniser chain for the asynchronous pin
  always_ff @(posedge clk) begin
    if (!rstN) begin
      syncQ <= '0;
      prevQ <= 1'b0;
    end else begin
      syncQ <= {syncQ[SYNC_STAGES-2:0], capPin};
      prevQ <= syncQ[LAST];
    end
  end

  assign seenRise = syncQ[LAST] & ~prevQ;
  assign seenFall = ~syncQ[LAST] & prevQ;

  always_comb begin
    stb.capture = edgeRise ? seenRise : seenFall;
    stb.loRead  = rdEn & ~rdAddr;
    stb.flagClr = flagWrEn & flagWrBit;
  end
endmodule

// File: rtl/capt_dp.sv
module capt_dp
  import capt_pkg::*;
#(
  parameter int CNT_W  = 16,
  parameter int BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  captStb_t          stb,
  input  logic [CNT_W-1:0]  cntVal,
  input  logic              rdAddr,
  output logic [BYTE_W-1:0] rdData,
  output logic              capFlag
);
  logic [CNT_W-1:0]  capReg;
  logic [BYTE_W-1:0] holdByte;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      capReg <= '0;
    end else if (stb.capture) begin
      capReg <= cntVal;
    end
  end

  // The holding byte takes the upper byte as it was before this edge
  always_ff @(posedge clk) begin
    if (!rstN) begin
      holdByte <= '0;
    end else if (stb.loRead) begin
      holdByte <= capReg[CNT_W-1 -: BYTE_W];
    end
  end

  // Setting has priority over clearing
  always_ff @(posedge clk) begin
    if (!rstN) begin
      capFlag <= 1'b0;
    end else if (stb.capture) begin
      capFlag <= 1'b1;
    end else if (stb.flagClr) begin
      capFlag <= 1'b0;
    end
  end

  assign rdData = rdAddr ? holdByte : capReg[BYTE_W-1:0];
endmodule

// File: rtl/capt_unit.sv
module capt_unit
  import capt_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        capPin,
  input  logic        edgeRise,
  input  logic [15:0] cntVal,
  input  logic        rdEn,
  input  logic        rdAddr,
  output logic [7:0]  rdData,
  input  logic        flagWrEn,
  input  logic        flagWrBit,
  output logic        capFlag
);
  captStb_t stb;

  capt_ctrl #(.SYNC_STAGES(2)) u_ctrl (
    .clk(clk), .rstN(rstN), .capPin(capPin), .edgeRise(edgeRise),
    .rdEn(rdEn), .rdAddr(rdAddr), .flagWrEn(flagWrEn), .flagWrBit(flagWrBit),
    .stb(stb)
  );

  capt_dp #(.CNT_W(16), .BYTE_W(8)) u_dp (
    .clk(clk), .rstN(rstN), .stb(stb), .cntVal(cntVal),
    .rdAddr(rdAddr), .rdData(rdData), .capFlag(capFlag)
  );
endmodule

// File: rtl/capt_checker.sv
module capt_checker
  import capt_pkg::*;
(
  input logic       clk,
  input logic       rstN,
  input logic       capFlag,
  input logic       rdAddr,
  input logic [7:0] rdData,
  input captStb_t   stb
);
  AST_CAPTURE_PULSE: assert property (@(posedge clk) disable iff (!rstN)
    stb.capture |=> !stb.capture); // R2
  AST_CAPTURE_SETS_FLAG: assert property (@(posedge clk) disable iff (!rstN)
    stb.capture |=> capFlag); // R6
  AST_FLAG_CLEARS: assert property (@(posedge clk) disable iff (!rstN)
    (stb.flagClr && !stb.capture) |=> !capFlag); // R5
  AST_FLAG_HOLDS: assert property (@(posedge clk) disable iff (!rstN)
    (capFlag && !stb.flagClr) |=> capFlag); // R5
  AST_FLAG_ONLY_ON_CAPTURE: assert property (@(posedge clk) disable iff (!rstN)
    $rose(capFlag) |-> $past(stb.capture)); // R5
  AST_HOLD_BYTE_STABLE: assert property (@(posedge clk) disable iff (!rstN)
    (rdAddr && $past(rdAddr) && !$past(stb.loRead)) |-> $stable(rdData)); // R8
endmodule

bind capt_unit capt_checker u_chk (.*);

// File: tb/test_capt_unit.sv
module test_capt_unit;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        capPin = 1'b0;
  logic        edgeRise = 1'b1;
  logic [15:0] cntVal = 16'h0000;
  logic        rdEn = 1'b0;
  logic        rdAddr = 1'b0;
  logic [7:0]  rdData;
  logic        flagWrEn = 1'b0;
  logic        flagWrBit = 1'b0;
  logic        capFlag;

  int nTests = 0;
  int nFail  = 0;
  bit done   = 1'b0;

  always #10 clk = ~clk; // 50 MHz

  capt_unit i_capt_unit (
    .clk(clk), .rstN(rstN), .capPin(capPin), .edgeRise(edgeRise),
    .cntVal(cntVal), .rdEn(rdEn), .rdAddr(rdAddr), .rdData(rdData),
    .flagWrEn(flagWrEn), .flagWrBit(flagWrBit), .capFlag(capFlag)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    nTests++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  // One accepted read; data sampled before the clock edge
  task automatic readByte(input logic addr, output logic [7:0] val);
    @(negedge clk);
    rdEn = 1'b1; rdAddr = addr;
    #1 val = rdData;
    @(negedge clk);
    rdEn = 1'b0; rdAddr = 1'b0;
  endtask

  task automatic readBoth(input string tag, input logic [15:0] exp);
    logic [7:0] lo, hi;
    readByte(1'b0, lo);
    readByte(1'b1, hi);
    check(lo == exp[7:0], {tag, " low"}, lo, exp[7:0]);
    check(hi == exp[15:8], {tag, " high"}, hi, exp[15:8]);
  endtask

  task automatic flagWrite(input logic bitVal);
    @(negedge clk);
    flagWrEn = 1'b1; flagWrBit = bitVal;
    @(negedge clk);
    flagWrEn = 1'b0; flagWrBit = 1'b0;
  endtask

  // Change the pin and wait until the capture edge (third rising edge) has passed
  task automatic movePin(input logic v);
    @(negedge clk);
    capPin = v;
    repeat (3) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic t_reset;
    check(capFlag == 1'b0, "R1 flag", capFlag, 0);
    readBoth("R1", 16'h0000);
  endtask

  task automatic t_rise;
    edgeRise = 1'b1; cntVal = 16'h12AB;
    @(negedge clk);
    capPin = 1'b1;
    repeat (2) @(posedge clk);
    @(negedge clk);
    check(capFlag == 1'b0, "R2 latency flag early", capFlag, 0);
    @(posedge clk);
    @(negedge clk);
    check(capFlag == 1'b1, "R5 flag set by capture", capFlag, 1);
    readBoth("R2 R7 rising capture", 16'h12AB);
  endtask

  task automatic t_flagClear;
    flagWrite(1'b0);
    check(capFlag == 1'b1, "R5 write zero ignored", capFlag, 1);
    flagWrite(1'b1);
    check(capFlag == 1'b0, "R5 write one clears", capFlag, 0);
  endtask

  task automatic t_wrongEdge;
    edgeRise = 1'b1; cntVal = 16'h5A5A;
    movePin(1'b0);
    repeat (2) @(negedge clk);
    check(capFlag == 1'b0, "R4 falling ignored in rising mode", capFlag, 0);
    readBoth("R4 register unchanged", 16'h12AB);
  endtask

  task automatic t_fall;
    edgeRise = 1'b0; cntVal = 16'h7777;
    movePin(1'b1);
    check(capFlag == 1'b0, "R4 rising ignored in falling mode", capFlag, 0);
    cntVal = 16'hBEEF;
    movePin(1'b0);
    check(capFlag == 1'b1, "R3 falling capture flag", capFlag, 1);
    readBoth("R3 falling capture", 16'hBEEF);
    flagWrite(1'b1);
  endtask

  task automatic t_clrCollide;
    edgeRise = 1'b1; cntVal = 16'h0F0F;
    @(negedge clk);
    capPin = 1'b1;
    repeat (2) @(posedge clk);
    @(negedge clk);
    flagWrEn = 1'b1; flagWrBit = 1'b1; // lands on the capture edge
    @(negedge clk);
    flagWrEn = 1'b0; flagWrBit = 1'b0;
    check(capFlag == 1'b1, "R6 capture beats clear", capFlag, 1);
    readBoth("R6 value", 16'h0F0F);
    flagWrite(1'b1);
  endtask

  task automatic t_midRead;
    logic [7:0] lo, hi;
    readByte(1'b0, lo);
    check(lo == 8'h0F, "R8 first low", lo, 8'h0F);
    edgeRise = 1'b0; cntVal = 16'hC3D4;
    movePin(1'b0);
    readByte(1'b1, hi);
    check(hi == 8'h0F, "R8 holding byte kept", hi, 8'h0F);
    readBoth("R8 fresh pair", 16'hC3D4);
    flagWrite(1'b1);
  endtask

  task automatic t_readCollide;
    logic [7:0] lo, hi;
    edgeRise = 1'b1; cntVal = 16'h9E61;
    @(negedge clk);
    capPin = 1'b1;
    repeat (2) @(posedge clk);
    @(negedge clk);
    rdEn = 1'b1; rdAddr = 1'b0; // low read on the capture edge
    #1 lo = rdData;
    @(negedge clk);
    rdEn = 1'b0;
    check(lo == 8'hD4, "R9 low read returns old", lo, 8'hD4);
    readByte(1'b1, hi);
    check(hi == 8'hC3, "R9 holding byte old high", hi, 8'hC3);
    check(capFlag == 1'b1, "R9 flag set", capFlag, 1);
    readBoth("R9 new pair", 16'h9E61);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    t_reset();
    t_rise();
    t_flagClear();
    t_wrongEdge();
    t_fall();
    t_clrCollide();
    t_midRead();
    t_readCollide();
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", nTests, nFail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      nTests++;
      nFail++;
      $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
      $display("[TB] %0d tests run, %0d failed", nTests, nFail);
      $finish;
    end
  end
endmodule